// File: doc/BRIEF.md
# Watermarked serial FIFO pair

This block holds the word buffering for a serial I/O peripheral. It has two independent first-in first-out queues of 32-bit words. The transmit queue is filled by a host-side register interface and drained by the serializer. The receive queue is filled by the serializer and drained by the host. Each queue moves exactly one whole word per accepted access, so a word is never split across several accesses. Both read ports are show-ahead: the oldest stored word is always presented, and a pop simply advances past it.

Each direction has a 3-bit watermark code that selects the fill level at which its request output rises. The transmit request compares free space against the code's threshold. The receive request compares stored words against the code's threshold. Either request can drive an interrupt line or a DMA trigger. A write into a full queue or a read from an empty queue is rejected and recorded in a sticky error bit. Software clears an error bit by writing a 1 to it.

Top module: `serfifo_pair`

## Requirements
- R1: Each queue stores up to 16 words of 32 bits and returns them in the order they were written. The read data port (`serTxData`, `hostRxData`) always shows the oldest stored word.
- R2: Each accepted push adds exactly one entry and each accepted pop removes exactly one entry. `txCount` and `rxCount` show the occupancy after each clock edge and never exceed 16.
- R3: A push into a full queue is dropped, and the stored words and the count are left unchanged. A host write to a full transmit queue sets `flags[0]`. A serializer push to a full receive queue sets `flags[2]`.
- R4: A pop from an empty queue is dropped and the count stays 0. A serializer pop of an empty transmit queue sets `flags[1]`. A host read of an empty receive queue sets `flags[3]`.
- R5: Error flags are sticky. A 1 in bit n of `flagClr` clears `flags[n]` at the next edge and leaves the other bits alone. If a new error for bit n happens in the same cycle as its clear, the bit stays set.
- R6: Whether a push or a pop is accepted depends only on the occupancy before the edge. A push and a pop in the same cycle leave the count unchanged when 0 < count < 16. With both at 16, the pop is taken and the push is rejected. With both at 0, the push is taken and the pop is rejected.
- R7: The transmit request follows free space (16 minus `txCount`) and `txMark`. Code 3'b000 raises it only when free = 16. Code 3'b100 raises it when free >= 12, 3'b101 when free >= 8, 3'b110 when free >= 4, and 3'b111 when free >= 1.
- R8: Transmit codes 3'b001, 3'b010 and 3'b011 behave exactly like 3'b000.
- R9: The receive request follows `rxCount` and `rxMark`. Code 3'b000, and codes 3'b001 to 3'b011, raise it when count >= 1. Code 3'b100 raises it at >= 4, 3'b101 at >= 8, 3'b110 at >= 12, and 3'b111 only when count = 16.
- R10: Each request is a registered level. It is updated at every edge from the occupancy resulting at that edge and from the code present before that edge. It falls at the same edge at which its condition stops holding.
- R11: Synchronous reset (`rst` high at an edge) empties both queues and clears all flags. Both requests stay low while reset is applied and until the first edge after its release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txMark | input | 3 | Transmit watermark code |
| rxMark | input | 3 | Receive watermark code |
| hostTxWr | input | 1 | Host pushes `hostTxData` into the transmit queue |
| hostTxData | input | 32 | Host write word |
| hostRxRd | input | 1 | Host pops the receive queue |
| hostRxData | output | 32 | Oldest word in the receive queue |
| serTxPop | input | 1 | Serializer pops the transmit queue |
| serTxData | output | 32 | Oldest word in the transmit queue |
| serRxPush | input | 1 | Serializer pushes `serRxData` into the receive queue |
| serRxData | input | 32 | Serializer receive word |
| txCount | output | 5 | Transmit occupancy |
| rxCount | output | 5 | Receive occupancy |
| txReq | output | 1 | Transmit request level |
| rxReq | output | 1 | Receive request level |
| flagClr | input | 4 | Write-1-to-clear strobes for `flags` |
| flags | output | 4 | Sticky errors: [0] tx overflow, [1] tx underflow, [2] rx overflow, [3] rx underflow |

## Verification
A drifting occupancy counter is visible on `txCount` or `rxCount` at the edge after the bad update. It also moves a request edge across a watermark boundary at that same edge. A pointer that slips, or a word lost on a rejected push, stays hidden until the affected slot reaches the head of its queue. It then shows as a wrong word on the show-ahead data port, up to 16 pops later. For that reason every queue is drained completely and compared word by word after each fill or overflow scenario.

// File: rtl/serfifo_pkg.sv
package serfifo_pkg;

  // Per-cycle accept strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
  } fifoStrobe_t;

  // Sticky error bit positions
  localparam int FLAG_TX_OVF = 0;
  localparam int FLAG_TX_UNF = 1;
  localparam int FLAG_RX_OVF = 2;
  localparam int FLAG_RX_UNF = 3;
  localparam int FLAG_N      = 4;

  // Watermark codes (001..011 are reserved and fall to the default)
  localparam logic [2:0] MARK_QTR  = 3'b100;
  localparam logic [2:0] MARK_HALF = 3'b101;
  localparam logic [2:0] MARK_3QTR = 3'b110;
  localparam logic [2:0] MARK_EDGE = 3'b111;

endpackage

// File: rtl/serfifo_store.sv
module serfifo_store #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (wrEn) wrPtr <= bump(wrPtr);
      if (rdEn) rdPtr <= bump(rdPtr);
    end
  end

  assign rdData = mem[rdPtr];

  // R1: head word only changes on a pop or a write into the head slot
  p_head_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!rdEn && !(wrEn && wrPtr == rdPtr)) |=> $stable(rdData));

endmodule

// File: rtl/serfifo_dpath.sv
module serfifo_dpath
  import serfifo_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  fifoStrobe_t      strobe,
  input  logic [WIDTH-1:0] hostTxData,
  input  logic [WIDTH-1:0] serRxData,
  output logic [WIDTH-1:0] serTxData,
  output logic [WIDTH-1:0] hostRxData
);
  // index 0 = transmit queue, index 1 = receive queue
  localparam int NQ = 2;
  logic             qWr   [NQ];
  logic             qRd   [NQ];
  logic [WIDTH-1:0] qIn   [NQ];
  logic [WIDTH-1:0] qOut  [NQ];

  assign qWr[0] = strobe.txPush;
  assign qRd[0] = strobe.txPop;
  assign qIn[0] = hostTxData;
  assign qWr[1] = strobe.rxPush;
  assign qRd[1] = strobe.rxPop;
  assign qIn[1] = serRxData;

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    serfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .clk    (clk),
      .rst    (rst),
      .wrEn   (qWr[q]),
      .wrData (qIn[q]),
      .rdEn   (qRd[q]),
      .rdData (qOut[q])
    );
  end

  assign serTxData  = qOut[0];
  assign hostRxData = qOut[1];

endmodule

// File: rtl/serfifo_ctrl.sv
module serfifo_ctrl
  import serfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        txMark,
  input  logic [2:0]        rxMark,
  input  logic              hostTxWr,
  input  logic              hostRxRd,
  input  logic              serTxPop,
  input  logic              serRxPush,
  input  logic [FLAG_N-1:0] flagClr,
  output fifoStrobe_t       strobe,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount,
  output logic              txReq,
  output logic              rxReq,
  output logic [FLAG_N-1:0] flags
);
  localparam logic [CNT_W-1:0] FULL   = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] QTR    = CNT_W'(DEPTH / 4);
  localparam logic [CNT_W-1:0] HALF   = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] TQTR   = CNT_W'(DEPTH - DEPTH / 4);

  logic             txFull, txEmpty, rxFull, rxEmpty;
  logic [CNT_W-1:0] txCountNxt, rxCountNxt, txFreeNxt;
  logic [FLAG_N-1:0] flagSet;

  // Free-space threshold for the transmit request
  function automatic logic [CNT_W-1:0] txThresh(input logic [2:0] code);
    case (code)
      MARK_QTR:  return TQTR;
      MARK_HALF: return HALF;
      MARK_3QTR: return QTR;
      MARK_EDGE: return ONE;
      default:   return FULL;
    endcase
  endfunction

  // Fill threshold for the receive request
  function automatic logic [CNT_W-1:0] rxThresh(input logic [2:0] code);
    case (code)
      MARK_QTR:  return QTR;
      MARK_HALF: return HALF;
      MARK_3QTR: return TQTR;
      MARK_EDGE: return FULL;
      default:   return ONE;
    endcase
  endfunction

  assign txFull  = (txCount == FULL);
  assign txEmpty = (txCount == '0);
  assign rxFull  = (rxCount == FULL);
  assign rxEmpty = (rxCount == '0);

  // Acceptance judged on occupancy before the edge
  always_comb begin
    strobe.txPush = hostTxWr  && !txFull;
    strobe.txPop  = serTxPop  && !txEmpty;
    strobe.rxPush = serRxPush && !rxFull;
    strobe.rxPop  = hostRxRd  && !rxEmpty;
  end

  always_comb begin
    txCountNxt = txCount + CNT_W'(strobe.txPush) - CNT_W'(strobe.txPop);
    rxCountNxt = rxCount + CNT_W'(strobe.rxPush) - CNT_W'(strobe.rxPop);
    txFreeNxt  = FULL - txCountNxt;
  end

  always_comb begin
    flagSet = '0;
    flagSet[FLAG_TX_OVF] = hostTxWr  && txFull;
    flagSet[FLAG_TX_UNF] = serTxPop  && txEmpty;
    flagSet[FLAG_RX_OVF] = serRxPush && rxFull;
    flagSet[FLAG_RX_UNF] = hostRxRd  && rxEmpty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txCount <= '0;
      rxCount <= '0;
      txReq   <= 1'b0;
      rxReq   <= 1'b0;
      flags   <= '0;
    end else begin
      txCount <= txCountNxt;
      rxCount <= rxCountNxt;
      txReq   <= (txFreeNxt >= txThresh(txMark));
      rxReq   <= (rxCountNxt >= rxThresh(rxMark));
      flags   <= (flags & ~flagClr) | flagSet;
    end
  end

  // R2: occupancy never exceeds the depth
  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (txCount <= FULL) && (rxCount <= FULL));

  // R3: a lone host write into a full transmit queue is dropped and flagged
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (txFull && hostTxWr && !serTxPop) |=> (txCount == FULL && flags[FLAG_TX_OVF]));

  // R4: a lone host read of an empty receive queue is dropped and flagged
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    (rxEmpty && hostRxRd && !serRxPush) |=> (rxCount == '0 && flags[FLAG_RX_UNF]));

  // R5: set flags survive unless cleared
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (|(flags & ~flagClr)) |=>
      ((flags & $past(flags & ~flagClr)) == $past(flags & ~flagClr)));

  // R6: push plus pop with room on both sides keeps occupancy
  p_both_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!txEmpty && !txFull && hostTxWr && serTxPop) |=> $stable(txCount));

  // R7: a transmit request always means there is room
  p_tx_req_room_r7: assert property (@(posedge clk) disable iff (rst)
    txReq |-> !txFull);

  // R9: a receive request always means there is data
  p_rx_req_data_r9: assert property (@(posedge clk) disable iff (rst)
    rxReq |-> !rxEmpty);

  // R11: the edge after reset leaves everything idle
  p_reset_idle_r11: assert property (@(posedge clk)
    rst |=> (!txReq && !rxReq && txCount == '0 && rxCount == '0 && flags == '0));

endmodule

// File: rtl/serfifo_pair.sv
module serfifo_pair
  import serfifo_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        txMark,
  input  logic [2:0]        rxMark,
  input  logic              hostTxWr,
  input  logic [WIDTH-1:0]  hostTxData,
  input  logic              hostRxRd,
  output logic [WIDTH-1:0]  hostRxData,
  input  logic              serTxPop,
  output logic [WIDTH-1:0]  serTxData,
  input  logic              serRxPush,
  input  logic [WIDTH-1:0]  serRxData,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount,
  output logic              txReq,
  output logic              rxReq,
  input  logic [FLAG_N-1:0] flagClr,
  output logic [FLAG_N-1:0] flags
);
  fifoStrobe_t strobe;

  serfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .txMark    (txMark),
    .rxMark    (rxMark),
    .hostTxWr  (hostTxWr),
    .hostRxRd  (hostRxRd),
    .serTxPop  (serTxPop),
    .serRxPush (serRxPush),
    .flagClr   (flagClr),
    .strobe    (strobe),
    .txCount   (txCount),
    .rxCount   (rxCount),
    .txReq     (txReq),
    .rxReq     (rxReq),
    .flags     (flags)
  );

  serfifo_dpath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .hostTxData (hostTxData),
    .serRxData  (serRxData),
    .serTxData  (serTxData),
    .hostRxData (hostRxData)
  );

endmodule

// File: tb/serfifo_pair_bench.sv
module serfifo_pair_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  txMark = '0, rxMark = '0;
  logic        hostTxWr = 1'b0, hostRxRd = 1'b0, serTxPop = 1'b0, serRxPush = 1'b0;
  logic [31:0] hostTxData = '0, serRxData = '0;
  logic [31:0] hostRxData, serTxData;
  logic [4:0]  txCount, rxCount;
  logic        txReq, rxReq;
  logic [3:0]  flagClr = '0;
  logic [3:0]  flags;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serfifo_pair u_serfifo_pair (
    .clk(clk), .rst(rst), .txMark(txMark), .rxMark(rxMark),
    .hostTxWr(hostTxWr), .hostTxData(hostTxData),
    .hostRxRd(hostRxRd), .hostRxData(hostRxData),
    .serTxPop(serTxPop), .serTxData(serTxData),
    .serRxPush(serRxPush), .serRxData(serRxData),
    .txCount(txCount), .rxCount(rxCount), .txReq(txReq), .rxReq(rxReq),
    .flagClr(flagClr), .flags(flags)
  );

  // {level[4:0], mark[2:0], expTxReq, expRxReq}
  localparam logic [9:0] VEC [16] = '{
    {5'd0,  3'b000, 1'b1, 1'b0},
    {5'd1,  3'b000, 1'b0, 1'b1},
    {5'd0,  3'b010, 1'b1, 1'b0},
    {5'd3,  3'b011, 1'b0, 1'b1},
    {5'd4,  3'b100, 1'b1, 1'b1},
    {5'd5,  3'b100, 1'b0, 1'b1},
    {5'd3,  3'b100, 1'b1, 1'b0},
    {5'd8,  3'b101, 1'b1, 1'b1},
    {5'd9,  3'b101, 1'b0, 1'b1},
    {5'd7,  3'b101, 1'b1, 1'b0},
    {5'd12, 3'b110, 1'b1, 1'b1},
    {5'd13, 3'b110, 1'b0, 1'b1},
    {5'd11, 3'b110, 1'b1, 1'b0},
    {5'd15, 3'b111, 1'b1, 1'b0},
    {5'd16, 3'b111, 1'b0, 1'b1},
    {5'd16, 3'b000, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    tick();
  endtask

  task automatic hostWrite(input logic [31:0] d);
    hostTxWr = 1'b1; hostTxData = d;
    tick();
    hostTxWr = 1'b0;
  endtask

  task automatic serPush(input logic [31:0] d);
    serRxPush = 1'b1; serRxData = d;
    tick();
    serRxPush = 1'b0;
  endtask

  task automatic serPop();
    serTxPop = 1'b1;
    tick();
    serTxPop = 1'b0;
  endtask

  task automatic hostRead();
    hostRxRd = 1'b1;
    tick();
    hostRxRd = 1'b0;
  endtask

  function automatic logic [31:0] txWord(input int i);
    return 32'h1000_0000 + 32'(i * 7);
  endfunction

  function automatic logic [31:0] rxWord(input int i);
    return 32'h5A00_0000 ^ 32'(i * 13);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    tick(); tick();
    chk("R11 txCount in reset", 32'(txCount), 0);
    chk("R11 rxCount in reset", 32'(rxCount), 0);
    chk("R11 txReq in reset", 32'(txReq), 0);
    chk("R11 rxReq in reset", 32'(rxReq), 0);
    chk("R11 flags in reset", 32'(flags), 0);
    rst = 1'b0;
    #1;
    chk("R11 txReq low before first edge after release", 32'(txReq), 0);
    tick();
    chk("R10 txReq high on empty queue after first edge", 32'(txReq), 1);

    // Watermark table: R7 R8 R9 R2
    for (int v = 0; v < 16; v++) begin
      logic [4:0] lvl;
      logic [2:0] mk;
      string ttag;
      lvl = VEC[v][9:5];
      mk  = VEC[v][4:2];
      txMark = mk;
      rxMark = mk;
      doReset();
      for (int k = 0; k < int'(lvl); k++) begin
        hostTxWr = 1'b1; hostTxData = txWord(k);
        serRxPush = 1'b1; serRxData = rxWord(k);
        tick();
        hostTxWr = 1'b0; serRxPush = 1'b0;
      end
      ttag = (mk == 3'b001 || mk == 3'b010 || mk == 3'b011) ? "R8 tx req reserved code" : "R7 tx req";
      chk(ttag, 32'(txReq), 32'(VEC[v][1]));
      chk("R9 rx req", 32'(rxReq), 32'(VEC[v][0]));
      chk("R2 txCount after fill", 32'(txCount), 32'(lvl));
    end

    // R1: transmit order
    txMark = 3'b000; rxMark = 3'b000;
    doReset();
    for (int i = 0; i < 16; i++) hostWrite(txWord(i));
    chk("R2 txCount full", 32'(txCount), 16);
    for (int i = 0; i < 16; i++) begin
      chk("R1 tx head word", serTxData, txWord(i));
      serPop();
    end
    chk("R2 txCount drained", 32'(txCount), 0);

    // R1: receive order
    for (int i = 0; i < 16; i++) serPush(rxWord(i));
    chk("R2 rxCount full", 32'(rxCount), 16);
    for (int i = 0; i < 16; i++) begin
      chk("R1 rx head word", hostRxData, rxWord(i));
      hostRead();
    end
    chk("R2 rxCount drained", 32'(rxCount), 0);
    chk("R4 no flags after clean traffic", 32'(flags), 0);

    // R3: overflow on both queues
    doReset();
    for (int i = 0; i < 16; i++) begin
      hostWrite(txWord(i + 40));
      serPush(rxWord(i + 40));
    end
    hostWrite(32'hDEAD_BEEF);
    chk("R3 txCount stays full", 32'(txCount), 16);
    chk("R3 tx overflow flag", 32'(flags), 4'b0001);
    serPush(32'hCAFE_F00D);
    chk("R3 rxCount stays full", 32'(rxCount), 16);
    chk("R3 rx overflow flag", 32'(flags), 4'b0101);
    for (int i = 0; i < 16; i++) begin
      chk("R3 tx contents unchanged", serTxData, txWord(i + 40));
      serPop();
      chk("R3 rx contents unchanged", hostRxData, rxWord(i + 40));
      hostRead();
    end

    // R4: underflow on both queues
    serPop();
    chk("R4 txCount stays empty", 32'(txCount), 0);
    chk("R4 tx underflow flag", 32'(flags), 4'b0111);
    hostRead();
    chk("R4 rxCount stays empty", 32'(rxCount), 0);
    chk("R4 rx underflow flag", 32'(flags), 4'b1111);

    // R5: selective clear and set-wins
    flagClr = 4'b0001; tick(); flagClr = '0;
    chk("R5 clear bit 0 only", 32'(flags), 4'b1110);
    flagClr = 4'b0010; serTxPop = 1'b1; tick(); flagClr = '0; serTxPop = 1'b0;
    chk("R5 new error wins over clear", 32'(flags), 4'b1110);
    flagClr = 4'b1110; tick(); flagClr = '0;
    chk("R5 clear remaining", 32'(flags), 0);
    tick();
    chk("R5 flags stay clear", 32'(flags), 0);

    // R6: simultaneous push and pop
    doReset();
    for (int i = 0; i < 5; i++) hostWrite(txWord(i + 80));
    hostTxWr = 1'b1; hostTxData = txWord(85); serTxPop = 1'b1;
    tick();
    hostTxWr = 1'b0; serTxPop = 1'b0;
    chk("R6 txCount unchanged mid-range", 32'(txCount), 5);
    chk("R6 head advanced", serTxData, txWord(81));
    chk("R6 no flag mid-range", 32'(flags), 0);
    serRxPush = 1'b1; serRxData = 32'h0BAD_C0DE; hostRxRd = 1'b1;
    tick();
    serRxPush = 1'b0; hostRxRd = 1'b0;
    chk("R6 rx empty push taken", 32'(rxCount), 1);
    chk("R6 rx empty pop rejected", 32'(flags), 4'b1000);
    chk("R6 rx word kept", hostRxData, 32'h0BAD_C0DE);
    for (int i = 0; i < 11; i++) hostWrite(txWord(i + 90));
    chk("R2 tx filled to 16", 32'(txCount), 16);
    hostTxWr = 1'b1; hostTxData = 32'hFFFF_0000; serTxPop = 1'b1;
    tick();
    hostTxWr = 1'b0; serTxPop = 1'b0;
    chk("R6 full: pop taken, push rejected", 32'(txCount), 15);
    chk("R6 full: overflow flagged", 32'(flags), 4'b1001);

    // R10: request drop and code timing
    doReset();
    rxMark = 3'b111;
    for (int i = 0; i < 16; i++) serPush(rxWord(i));
    chk("R10 rxReq at 16 with code 111", 32'(rxReq), 1);
    hostRead();
    chk("R10 rxReq drops at same edge", 32'(rxReq), 0);
    rxMark = 3'b110;
    #1;
    chk("R10 code change waits for edge", 32'(rxReq), 0);
    tick();
    chk("R10 new code applied after edge", 32'(rxReq), 1);
    txMark = 3'b110;
    for (int i = 0; i < 12; i++) hostWrite(txWord(i));
    chk("R10 txReq at free 4 code 110", 32'(txReq), 1);
    hostWrite(txWord(12));
    chk("R10 txReq drops at free 3", 32'(txReq), 0);

    // R11: reset in the middle of traffic
    serRxPush = 1'b1; serRxData = 32'h1234_5678; hostTxWr = 1'b1;
    tick();
    serRxPush = 1'b0; hostTxWr = 1'b0;
    rst = 1'b1;
    tick();
    chk("R11 txCount cleared", 32'(txCount), 0);
    chk("R11 rxCount cleared", 32'(rxCount), 0);
    chk("R11 txReq cleared", 32'(txReq), 0);
    chk("R11 rxReq cleared", 32'(rxReq), 0);
    chk("R11 flags cleared", 32'(flags), 0);
    rst = 1'b0;
    tick();
    chk("R11 txReq back on empty queue", 32'(txReq), 1);
    chk("R11 rxReq stays low on empty queue", 32'(rxReq), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule